// File: doc/BRIEF.md
# Time-of-Day BCD Counter

This block keeps the wall-clock time of day as six BCD digits: tens and units of hours, minutes and seconds. It advances by one second on every clock cycle in which the one-cycle `tick` enable is high. Seconds and minutes wrap after 59, and hours wrap after 23, so the largest time shown is 23:59:59. Each wrap is decided synchronously from the terminal value before the increment. Because of this, no out-of-range digit pair ever appears on the outputs, not even for one cycle.

A two-bit mode input lets firmware or front-panel logic set the time by hand. In either adjust mode the seconds are held at 00 and the tick is ignored. Each `adj` pulse then steps the minutes or the hours by one, with wrap-around. Single-cycle strobes mark each minute and hour carry. A chime flag marks the top of every hour, for use by a downstream buzzer or alarm stage.

All outputs are registered. Every change appears one clock after the edge that sampled the inputs.

Top module: `tod_counter`

## Requirements
- R1: Every digit is BCD (units 0 to 9). Seconds and minutes run from 00 to 59. Each tick in run mode adds one second, and a units digit wrapping from 9 to 0 advances its tens digit.
- R2: A tick at seconds 59 gives seconds 00 and advances the minutes. In the same cycle as the new value, `min_carry` is high for exactly one cycle.
- R3: A tick at mm:ss = 59:59 gives minutes 00 and advances the hours. `hr_carry` is high for one cycle together with `min_carry`.
- R4: A tick at 23:59:59 gives 00:00:00. The hour value never reaches 24 or more.
- R5: In run mode, a cycle with `tick` low leaves every digit unchanged, and both carry strobes are low.
- R6: `set_mode` encoding: 2'b00 is run, 2'b01 is minute adjust, 2'b10 is hour adjust, and 2'b11 is also run. In either adjust mode the seconds become 00 on the next cycle, `tick` is ignored, and the strobes and chime are low.
- R7: In minute adjust, each `adj` pulse adds one minute and wraps 59 to 00. Hours stay unchanged and no `hr_carry` is issued.
- R8: In hour adjust, each `adj` pulse adds one hour and wraps 23 to 00. Minutes stay unchanged.
- R9: In run mode `adj` has no effect on any output.
- R10: `chime` rises on the cycle the count reaches mm:ss = 00:00 through a tick, and stays high until the next tick. It is low in adjust modes and after reset. Over a full day of ticks it rises exactly 24 times.
- R11: A synchronous active-high `rst` clears all six digits to zero and drives `chime`, `min_carry` and `hr_carry` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable |
| set_mode | input | 2 | 00/11 run, 01 minute adjust, 10 hour adjust |
| adj | input | 1 | Manual step pulse for the selected field |
| hr_tens | output | 4 | Hours tens digit |
| hr_units | output | 4 | Hours units digit |
| min_tens | output | 4 | Minutes tens digit |
| min_units | output | 4 | Minutes units digit |
| sec_tens | output | 4 | Seconds tens digit |
| sec_units | output | 4 | Seconds units digit |
| chime | output | 1 | Top-of-hour flag |
| min_carry | output | 1 | One-cycle strobe on seconds wrap |
| hr_carry | output | 1 | One-cycle strobe on minutes wrap |

## Verification
The assertions assume that `set_mode` is one of the four listed codes and that `tick` and `adj` are single-cycle pulses held clean between edges. They also assume that the digits start from reset and are never loaded from outside, so range checks hold only because every value is reached by counting. The stimulus always begins with reset and changes inputs only on falling edges. Mode changes are placed between ticks, and every path to 23:59 is reached through ticks or adjust pulses alone.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t DIGIT_MAX = 4'd9;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } bcd_pair_t;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_SET_MIN = 2'b01,
        MODE_SET_HR  = 2'b10,
        MODE_RUN_ALT = 2'b11
    } set_mode_e;

    typedef struct packed {
        bcd_pair_t hr;
        bcd_pair_t min;
        bcd_pair_t sec;
        logic      chime;
        logic      min_carry;
        logic      hr_carry;
    } tod_state_t;
endpackage

// File: rtl/bcd_pair_step.sv
module bcd_pair_step
    import tod_pkg::*;
#(
    parameter digit_t TOP_TENS  = 4'd5,
    parameter digit_t TOP_UNITS = 4'd9
) (
    input  bcd_pair_t cur,
    input  logic      inc,
    output bcd_pair_t nxt,
    output logic      at_top
);
    always_comb begin
        at_top = (cur.tens == TOP_TENS) && (cur.units == TOP_UNITS);
        nxt    = cur;
        if (inc) begin
            if (at_top) begin
                nxt = '0;
            end else if (cur.units == DIGIT_MAX) begin
                nxt.units = '0;
                nxt.tens  = cur.tens + digit_t'(1);
            end else begin
                nxt.units = cur.units + digit_t'(1);
            end
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter digit_t MS_TOP_TENS  = 4'd5,
    parameter digit_t MS_TOP_UNITS = 4'd9,
    parameter digit_t HR_TOP_TENS  = 4'd2,
    parameter digit_t HR_TOP_UNITS = 4'd3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] set_mode,
    input  logic       adj,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units,
    output logic       chime,
    output logic       min_carry,
    output logic       hr_carry
);
    tod_state_t state_d, state_q;
    set_mode_e  mode;
    logic       run_mode;
    logic       sec_inc, min_inc, hr_inc;
    logic       sec_top, min_top, hr_top;
    bcd_pair_t  sec_nxt, min_nxt, hr_nxt;

    assign mode     = set_mode_e'(set_mode);
    assign run_mode = (mode == MODE_RUN) || (mode == MODE_RUN_ALT);

    // carry chain: seconds feed minutes feed hours in run mode;
    // adjust pulses enter at the selected field in set mode
    assign sec_inc = run_mode && tick;
    assign min_inc = run_mode ? (tick && sec_top) : ((mode == MODE_SET_MIN) && adj);
    assign hr_inc  = run_mode ? (tick && sec_top && min_top) : ((mode == MODE_SET_HR) && adj);

    bcd_pair_step #(.TOP_TENS(MS_TOP_TENS), .TOP_UNITS(MS_TOP_UNITS)) u_sec_step (
        .cur(state_q.sec), .inc(sec_inc), .nxt(sec_nxt), .at_top(sec_top)
    );
    bcd_pair_step #(.TOP_TENS(MS_TOP_TENS), .TOP_UNITS(MS_TOP_UNITS)) u_min_step (
        .cur(state_q.min), .inc(min_inc), .nxt(min_nxt), .at_top(min_top)
    );
    bcd_pair_step #(.TOP_TENS(HR_TOP_TENS), .TOP_UNITS(HR_TOP_UNITS)) u_hr_step (
        .cur(state_q.hr), .inc(hr_inc), .nxt(hr_nxt), .at_top(hr_top)
    );

    always_comb begin
        state_d           = state_q;
        state_d.sec       = run_mode ? sec_nxt : '0;
        state_d.min       = min_nxt;
        state_d.hr        = hr_nxt;
        state_d.min_carry = run_mode && tick && sec_top;
        state_d.hr_carry  = run_mode && tick && sec_top && min_top;
        if (!run_mode) begin
            state_d.chime = 1'b0;
        end else if (tick) begin
            state_d.chime = state_d.hr_carry;
        end else begin
            state_d.chime = state_q.chime;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hr_tens   = state_q.hr.tens;
    assign hr_units  = state_q.hr.units;
    assign min_tens  = state_q.min.tens;
    assign min_units = state_q.min.units;
    assign sec_tens  = state_q.sec.tens;
    assign sec_units = state_q.sec.units;
    assign chime     = state_q.chime;
    assign min_carry = state_q.min_carry;
    assign hr_carry  = state_q.hr_carry;

    // R1
    bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_units <= 4'd9) && (min_units <= 4'd9) && (hr_units <= 4'd9) &&
        (sec_tens <= 4'd5) && (min_tens <= 4'd5));

    // R2
    min_carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        min_carry |-> (sec_tens == 4'd0) && (sec_units == 4'd0));

    // R3
    hr_carry_pair_chk: assert property (@(posedge clk) disable iff (rst)
        hr_carry |-> min_carry && (min_tens == 4'd0) && (min_units == 4'd0));

    // R4
    hr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (hr_tens < 4'd2) || ((hr_tens == 4'd2) && (hr_units <= 4'd3)));

    // R4
    day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run_mode && tick && hr_top && min_top && sec_top) |=>
        (hr_tens == 4'd0) && (hr_units == 4'd0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && (set_mode == 2'b00 || set_mode == 2'b11)) |=>
        $stable({hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units}) &&
        !min_carry && !hr_carry);

    // R6
    set_sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mode == 2'b01 || set_mode == 2'b10) |=>
        (sec_tens == 4'd0) && (sec_units == 4'd0) && !min_carry && !hr_carry && !chime);

    // R7
    min_adj_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mode == 2'b01) |=> $stable({hr_tens, hr_units}));

    // R8
    hr_adj_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mode == 2'b10) |=> $stable({min_tens, min_units}));

    // R10
    chime_top_chk: assert property (@(posedge clk) disable iff (rst)
        chime |-> (min_tens == 4'd0) && (min_units == 4'd0) &&
                  (sec_tens == 4'd0) && (sec_units == 4'd0));
endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] set_mode = 2'b00;
    logic       adj = 1'b0;
    logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
    logic       chime, min_carry, hr_carry;

    int vectors = 0;
    int errors  = 0;
    int exp_h = 0, exp_m = 0, exp_s = 0;
    int exp_chime = 0, exp_mc = 0, exp_hc = 0;
    int chime_rises = 0, hc_seen = 0;
    logic prev_chime = 1'b0;

    always #4 clk = ~clk;

    tod_counter dut (
        .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode), .adj(adj),
        .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
        .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units),
        .chime(chime), .min_carry(min_carry), .hr_carry(hr_carry)
    );

    task automatic compare(input string tag);
        int ah, am, as_;
        ah  = int'(hr_tens) * 10 + int'(hr_units);
        am  = int'(min_tens) * 10 + int'(min_units);
        as_ = int'(sec_tens) * 10 + int'(sec_units);
        vectors++;
        if (hr_units > 4'd9 || min_units > 4'd9 || sec_units > 4'd9 ||
            ah != exp_h || am != exp_m || as_ != exp_s ||
            int'(chime) != exp_chime || int'(min_carry) != exp_mc ||
            int'(hr_carry) != exp_hc) begin
            errors++;
            $display("FAIL %s: got %0d:%0d:%0d c%0d m%0d h%0d, expected %0d:%0d:%0d c%0d m%0d h%0d",
                     tag, ah, am, as_, chime, min_carry, hr_carry,
                     exp_h, exp_m, exp_s, exp_chime, exp_mc, exp_hc);
        end
        if (chime && !prev_chime) chime_rises++;
        if (hr_carry) hc_seen++;
        prev_chime = chime;
    endtask

    task automatic model(input logic t, input logic [1:0] md, input logic a);
        bit run;
        run = (md == 2'b00) || (md == 2'b11);
        if (run) begin
            exp_mc = 0;
            exp_hc = 0;
            if (t) begin
                exp_s++;
                if (exp_s == 60) begin
                    exp_s = 0; exp_mc = 1; exp_m++;
                    if (exp_m == 60) begin
                        exp_m = 0; exp_hc = 1; exp_h++;
                        if (exp_h == 24) exp_h = 0;
                    end
                end
                exp_chime = exp_hc;
            end
        end else begin
            exp_s = 0; exp_mc = 0; exp_hc = 0; exp_chime = 0;
            if (a) begin
                if (md == 2'b01) exp_m = (exp_m + 1) % 60;
                else             exp_h = (exp_h + 1) % 24;
            end
        end
    endtask

    task automatic cyc(input logic t, input logic [1:0] md, input logic a, input string tag);
        tick = t; set_mode = md; adj = a;
        @(posedge clk);
        model(t, md, a);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; tick = 1'b0; set_mode = 2'b00; adj = 1'b0;
        @(posedge clk);
        exp_h = 0; exp_m = 0; exp_s = 0; exp_chime = 0; exp_mc = 0; exp_hc = 0;
        @(negedge clk);
        compare(tag);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish before 200000 cycles");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R11 reset state
        do_reset("R11");
        // R5 idle cycles hold
        for (int i = 0; i < 5; i++) cyc(1'b0, 2'b00, 1'b0, "R5");
        // R9 adj ignored in run mode
        for (int i = 0; i < 3; i++) cyc(1'b0, 2'b00, 1'b1, "R9");
        cyc(1'b1, 2'b00, 1'b1, "R9");
        do_reset("R11");

        // full day with occasional idle cycles; R1 R2 R3 R4 R10
        chime_rises = 0; hc_seen = 0;
        for (int i = 0; i < 86400; i++) begin
            string tg;
            if (exp_s == 59 && exp_m == 59 && exp_h == 23) tg = "R4";
            else if (exp_s == 59 && exp_m == 59)          tg = "R3";
            else if (exp_s == 59)                         tg = "R2";
            else                                          tg = "R1";
            cyc(1'b1, (i % 7 == 3) ? 2'b11 : 2'b00, 1'b0, tg);
            if (i % 997 == 0) cyc(1'b0, 2'b00, 1'b0, "R5");
        end
        vectors++;
        if (chime_rises != 24) begin
            errors++;
            $display("FAIL R10: chime rises %0d, expected 24", chime_rises);
        end
        vectors++;
        if (hc_seen != 24) begin
            errors++;
            $display("FAIL R3: hr_carry pulses %0d, expected 24", hc_seen);
        end

        // run partway, then enter minute adjust: R6 R7
        for (int i = 0; i < 75; i++) cyc(1'b1, 2'b00, 1'b0, "R1");
        cyc(1'b1, 2'b01, 1'b0, "R6");
        for (int i = 0; i < 61; i++) cyc(1'b1, 2'b01, 1'b1, "R7");
        cyc(1'b0, 2'b01, 1'b0, "R6");
        // hour adjust with wrap: R8
        for (int i = 0; i < 25; i++) cyc(1'b0, 2'b10, 1'b1, "R8");
        // drive to 23:59 by hand
        while (exp_h != 23) cyc(1'b0, 2'b10, 1'b1, "R8");
        while (exp_m != 59) cyc(1'b0, 2'b01, 1'b1, "R7");
        // resume and cross midnight: R4 R10
        for (int i = 0; i < 62; i++) cyc(1'b1, 2'b00, 1'b0, exp_s == 59 ? "R4" : "R1");
        for (int i = 0; i < 3; i++) cyc(1'b0, 2'b00, 1'b0, "R10");
        cyc(1'b0, 2'b10, 1'b0, "R10");
        // reset mid-run
        for (int i = 0; i < 10; i++) cyc(1'b1, 2'b00, 1'b0, "R1");
        do_reset("R11");
        finish_run();
    end
endmodule